// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block sits between reset and a processor core. Once reset is released, it reads the two leading words of boot memory through a simple request/valid read port. The word at byte address 0 becomes the initial stack pointer. The word at byte address 4 becomes the entry point. Bit 0 of the entry word is split off into an instruction-set state flag, and the address handed to the core has that bit cleared. When all values are in place, the sequencer pulses a start signal for one cycle. The values it presented then stay frozen until the next reset.

A bypass input is sampled in the single idle cycle after reset. When it is high, the sequencer performs no memory reads. It takes the supplied entry address as the program counter source and splits it the same way. The stack pointer keeps its reset value of zero.

Top module: `boot_vec_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle: `mem_rd_req`, `core_start`, `core_isa_bit`, `core_sp` and `core_pc` are all zero after that edge.
- R2: Without bypass, the first read is issued to byte address 0. The 32-bit word returned with `mem_rd_valid` appears on `core_sp` from the next cycle.
- R3: The second read is issued to byte address 4. From the cycle after its valid, `core_pc` equals that word with bit 0 forced to 0, and `core_isa_bit` equals bit 0 of the word.
- R4: Each read waits for `mem_rd_valid`. Until it arrives, `mem_rd_req` stays high and `mem_rd_addr` does not change. With a response latency of L cycles per read, `core_start` rises 4+2L cycles after reset release.
- R5: `core_start` is high for exactly one cycle per reset, in the cycle after the entry value is captured.
- R6: With `bypass_en` high in the first cycle after reset, no read is issued. `core_pc` becomes `bypass_entry` with bit 0 cleared, `core_isa_bit` becomes bit 0 of `bypass_entry`, and `core_start` is high in the first cycle after that.
- R7: In bypass mode, `core_sp` stays 0 even though memory holds a non-zero word at address 0.
- R8: After start, the outputs hold their values until reset. Stray `mem_rd_valid` pulses, changes on `mem_rd_data`, and changes on `bypass_en` and `bypass_entry` have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Use the supplied entry address instead of the vector table |
| bypass_entry | input | WORD_W | Supplied entry address, bit 0 is the state flag |
| mem_rd_req | output | 1 | Read request, held until valid |
| mem_rd_addr | output | ADDR_W | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | WORD_W | Read data word |
| core_sp | output | WORD_W | Initial stack pointer |
| core_pc | output | WORD_W | Initial program counter, bit 0 clear |
| core_isa_bit | output | 1 | Instruction-set state flag |
| core_start | output | 1 | One-cycle start pulse |

## Verification
The bench varies the read latency from zero to several cycles. A design that drops its request early, or that moves to the next fetch without a valid, either starts at the wrong cycle or reads the wrong address order. It uses entry words with bit 0 both set and clear, including all-ones. A design that forgets to clear bit 0, or that takes the flag from the wrong bit, then shows a wrong `core_pc` or `core_isa_bit`. Bypass runs put a non-zero word at address 0, so a design that still loads the stack pointer, or that issues reads in bypass mode, is caught. After start, stray valid pulses and bypass toggles are injected to expose any design that re-captures values or pulses start a second time.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GET_SP = 2'd1,
    ST_GET_PC = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/boot_vec_split.sv
module boot_vec_split #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] addr_out,
  output logic              state_bit
);
  assign addr_out  = {word_in[WORD_W-1:1], 1'b0};
  assign state_bit = word_in[0];
endmodule

// File: rtl/boot_vec_fsm.sv
module boot_vec_fsm
  import boot_vec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_en,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_sp,
  output logic              cap_pc,
  output logic              cap_byp,
  output logic              locked,
  output logic              start
);
  localparam logic [ADDR_W-1:0] SP_OFF = '0;
  localparam logic [ADDR_W-1:0] PC_OFF = ADDR_W'(WORD_W / 8);

  seq_state_t st;
  logic       start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (bypass_en) begin
            st      <= ST_DONE;
            start_q <= 1'b1;
          end else begin
            st <= ST_GET_SP;
          end
        end
        ST_GET_SP: if (rd_valid) st <= ST_GET_PC;
        ST_GET_PC: begin
          if (rd_valid) begin
            st      <= ST_DONE;
            start_q <= 1'b1;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  assign rd_req  = (st == ST_GET_SP) || (st == ST_GET_PC);
  assign rd_addr = (st == ST_GET_PC) ? PC_OFF : SP_OFF;
  assign cap_sp  = (st == ST_GET_SP) && rd_valid;
  assign cap_pc  = (st == ST_GET_PC) && rd_valid;
  assign cap_byp = (st == ST_IDLE) && bypass_en;
  assign locked  = (st == ST_DONE);
  assign start   = start_q;

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R6
  bypass_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && bypass_en) |=> (!rd_req && start));
endmodule

// File: rtl/boot_vec_regs.sv
module boot_vec_regs #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_sp,
  input  logic              cap_entry,
  input  logic              locked,
  input  logic [WORD_W-1:0] sp_word,
  input  logic [WORD_W-1:0] entry_addr,
  input  logic              entry_bit,
  output logic [WORD_W-1:0] sp_q,
  output logic [WORD_W-1:0] pc_q,
  output logic              isa_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      pc_q  <= '0;
      isa_q <= 1'b0;
    end else begin
      if (cap_sp) sp_q <= sp_word;
      if (cap_entry) begin
        pc_q  <= entry_addr;
        isa_q <= entry_bit;
      end
    end
  end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(sp_q) && $stable(pc_q) && $stable(isa_q)));
endmodule

// File: rtl/boot_vec_seq.sv
module boot_vec_seq #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_en,
  input  logic [WORD_W-1:0] bypass_entry,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic [WORD_W-1:0] core_sp,
  output logic [WORD_W-1:0] core_pc,
  output logic              core_isa_bit,
  output logic              core_start
);
  localparam logic [ADDR_W-1:0] SP_OFF = '0;
  localparam logic [ADDR_W-1:0] PC_OFF = ADDR_W'(WORD_W / 8);

  logic              cap_sp, cap_pc, cap_byp, locked;
  logic [WORD_W-1:0] entry_src, entry_addr;
  logic              entry_bit;

  boot_vec_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .bypass_en(bypass_en),
    .rd_valid (mem_rd_valid),
    .rd_req   (mem_rd_req),
    .rd_addr  (mem_rd_addr),
    .cap_sp   (cap_sp),
    .cap_pc   (cap_pc),
    .cap_byp  (cap_byp),
    .locked   (locked),
    .start    (core_start)
  );

  assign entry_src = cap_byp ? bypass_entry : mem_rd_data;

  boot_vec_split #(.WORD_W(WORD_W)) u_split (
    .word_in  (entry_src),
    .addr_out (entry_addr),
    .state_bit(entry_bit)
  );

  boot_vec_regs #(.WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cap_sp    (cap_sp),
    .cap_entry (cap_pc || cap_byp),
    .locked    (locked),
    .sp_word   (mem_rd_data),
    .entry_addr(entry_addr),
    .entry_bit (entry_bit),
    .sp_q      (core_sp),
    .pc_q      (core_pc),
    .isa_q     (core_isa_bit)
  );

  // R2
  sp_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_addr == SP_OFF && mem_rd_valid)
      |=> (core_sp == $past(mem_rd_data)));

  // R3
  pc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_addr == PC_OFF && mem_rd_valid)
      |=> (core_pc[WORD_W-1:1] == $past(mem_rd_data[WORD_W-1:1]) &&
           !core_pc[0] && core_isa_bit == $past(mem_rd_data[0])));
endmodule

// File: tb/boot_vec_seq_tb.sv
`timescale 1ns/1ps
module boot_vec_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bypass_en = 1'b0;
  logic [31:0] bypass_entry = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic [31:0] core_sp, core_pc;
  logic        core_isa_bit, core_start;

  logic        rsp_valid = 1'b0, inj_valid = 1'b0;
  logic [31:0] rsp_data = '0, inj_data = '0;
  assign mem_rd_valid = rsp_valid | inj_valid;
  assign mem_rd_data  = inj_valid ? inj_data : rsp_data;

  always #10 clk = ~clk;

  boot_vec_seq u_dut (.*);

  typedef struct {logic [31:0] sp; logic [31:0] pc; logic isa;} exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  int lat = 0, wait_cnt = 0, reads = 0, starts = 0, cyc = 0, start_cyc = -1;
  logic [31:0] w0 = '0, w1 = '0;
  logic [31:0] addr_log [0:1];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // memory responder
  always @(negedge clk) begin
    if (rst) begin
      rsp_valid = 1'b0;
      wait_cnt  = 0;
    end else if (rsp_valid) begin
      rsp_valid = 1'b0;
    end else if (mem_rd_req) begin
      if (wait_cnt >= lat) begin
        rsp_valid = 1'b1;
        rsp_data  = (mem_rd_addr == 32'd0) ? w0 :
                    (mem_rd_addr == 32'd4) ? w1 : 32'hBAD0_BAD0;
        if (reads < 2) addr_log[reads] = mem_rd_addr;
        reads++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && core_start) begin
      starts++;
      start_cyc = cyc;
      if (sb.size() == 0) begin
        chk("R5 unexpected start", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R2/R7 sp at start", core_sp, e.sp);
        chk("R3/R6 pc at start", core_pc, e.pc);
        chk("R3/R6 isa bit at start", {31'd0, core_isa_bit}, {31'd0, e.isa});
      end
    end
  end

  task automatic run_boot(bit byp, logic [31:0] entry, logic [31:0] a0,
                          logic [31:0] a1, int l);
    exp_t e;
    logic [31:0] src, sp_s, pc_s;
    logic        isa_s;
    w0 = a0; w1 = a1; lat = l;
    bypass_en = byp; bypass_entry = entry;
    rst = 1'b1;
    step(); step();
    // R1 reset state
    chk("R1 req", {31'd0, mem_rd_req}, 32'd0);
    chk("R1 start", {31'd0, core_start}, 32'd0);
    chk("R1 sp", core_sp, 32'd0);
    chk("R1 pc", core_pc, 32'd0);
    chk("R1 isa", {31'd0, core_isa_bit}, 32'd0);
    reads = 0; starts = 0; start_cyc = -1;
    src = byp ? entry : a1;
    e.sp = byp ? 32'd0 : a0;
    e.pc = {src[31:1], 1'b0};
    e.isa = src[0];
    sb.push_back(e);
    rst = 1'b0;
    repeat (30) step();
    chk("R5 one start pulse", starts, 1);
    chk(byp ? "R6 start cycle" : "R4 start cycle", start_cyc, byp ? 1 : 4 + 2 * l);
    chk(byp ? "R6 no reads" : "R2 read count", reads, byp ? 0 : 2);
    if (!byp) begin
      chk("R2 first address", addr_log[0], 32'd0);
      chk("R3 second address", addr_log[1], 32'd4);
    end else begin
      chk("R7 sp stays zero", core_sp, 32'd0);
    end
    chk("R5 scoreboard drained", sb.size(), 0);
    // R8 stray stimulus after start
    sp_s = core_sp; pc_s = core_pc; isa_s = core_isa_bit;
    inj_data = 32'h1357_9BDF; inj_valid = 1'b1;
    bypass_en = ~byp; bypass_entry = 32'hCAFE_F00D;
    step();
    inj_valid = 1'b0;
    step(); step();
    chk("R8 sp hold", core_sp, sp_s);
    chk("R8 pc hold", core_pc, pc_s);
    chk("R8 isa hold", {31'd0, core_isa_bit}, {31'd0, isa_s});
    chk("R8 no second start", starts, 1);
    chk("R8 no stray request", {31'd0, mem_rd_req}, 32'd0);
  endtask

  initial begin
    run_boot(1'b0, 32'h0,         32'h2000_1000, 32'h0000_0101, 0);
    run_boot(1'b0, 32'h0,         32'h2000_0800, 32'h0800_0200, 3);
    run_boot(1'b1, 32'h0000_4001, 32'h2000_4000, 32'h0000_0301, 0);
    run_boot(1'b1, 32'h1000_0000, 32'h2000_4000, 32'h0000_0301, 2);
    run_boot(1'b0, 32'h0000_8001, 32'h2001_0000, 32'hFFFF_FFFF, 1);
    run_boot(1'b0, 32'h0,         32'hFFFF_FFFC, 32'h0000_0000, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule